// File: doc/BRIEF.md
# Sector Program Sequencer with Status Polling

This block carries out the self-timed rewrite of one sector of a small on-chip byte array. A loader fills a page buffer with the bytes meant for a sector, then pulses `start` with the sector number on `prog_sec`. The sequencer first runs an erase phase and then a program phase, each timed by an internal counter.

In the erase phase every location of the sector is forced to FFh. In the program phase each location receives its buffered byte, or stays FFh if no byte was loaded for it. The buffer's valid map is cleared when the cycle ends. `busy` is high for the whole cycle.

A reader uses the chip-style enables `ce_n`, `oe_n` and `we_n`. The output enable `data_oe` is raised only for a true read. While the cycle runs, any read returns a status byte instead of array data. Its bit 7 is the inverse of bit 7 of the last byte loaded, so software polls until that bit turns true. Once the cycle has finished, reads return the array contents again.

Top module: `sector_prog_seq`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` on the next clock edge.
- R2: `busy` stays high for exactly ERASE_CYC + PROG_CYC + 2·2^OFF_W clock cycles: an erase wait, an erase sweep of one location per cycle, a program wait, and a program sweep of one location per cycle. `busy` falls the cycle after the last location is written.
- R3: After a cycle, each location of the target sector that received no buffer write since the previous cycle reads FFh. The valid map of the buffer is empty again after every cycle.
- R4: After a cycle, each loaded location reads the byte most recently written to its buffer slot.
- R5: While `busy` is high, a read at any address returns `data_out[7]` = NOT (bit 7 of the last accepted buffer write) and `data_out[6:0]` = 0.
- R6: Once `busy` is low, reads return array contents, so the last loaded byte reads with its true bit 7.
- R7: `data_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1; otherwise it is 0.
- R8: While `busy` is high, `start` pulses and buffer writes are ignored. The cycle length is unchanged, and such a write does not appear in the next cycle.
- R9: A cycle writes only the sector captured from `prog_sec` at `start`; other sectors keep their contents.
- R10: After reset, `busy` is 0, the buffer holds no valid bytes, and the last-loaded bit 7 is taken as 0, so a poll returns bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_wr | input | 1 | Page buffer write strobe |
| buf_off | input | OFF_W | Byte offset within the sector for the buffer write |
| buf_data | input | 8 | Byte written to the buffer |
| start | input | 1 | Begin a sector cycle (single-cycle pulse) |
| prog_sec | input | SEC_W | Target sector, captured with `start` |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | SEC_W+OFF_W | Read address: {sector, offset} |
| busy | output | 1 | High while the erase/program cycle runs |
| data_out | output | 8 | Array data or status byte |
| data_oe | output | 1 | Output driver enable |

## Verification
The hardest situation to reach from the ports is a collision between the running cycle and new loader activity. This means a `start` pulse and a buffer write that land in the middle of the sweep, followed by a check that neither lengthened the cycle nor leaked into the next one. The stimulus issues both at a fixed cycle count inside the busy window. It measures the busy length edge by edge, then runs a second cycle on another sector and reads the poked offset back as FFh. Status polls are also taken mid-cycle with last-loaded bit 7 values of 0, 1 and the reset default, so that the inversion shows in all three cases.

// File: rtl/sector_prog_seq.sv
module sector_prog_seq #(
  parameter int OFF_W     = 8,
  parameter int SEC_W     = 2,
  parameter int ERASE_CYC = 1000,
  parameter int PROG_CYC  = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   buf_wr,
  input  logic [OFF_W-1:0]       buf_off,
  input  logic [7:0]             buf_data,
  input  logic                   start,
  input  logic [SEC_W-1:0]       prog_sec,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [SEC_W+OFF_W-1:0] rd_addr,
  output logic                   busy,
  output logic [7:0]             data_out,
  output logic                   data_oe
);
  localparam int SLOTS = 1 << OFF_W;
  localparam int DEPTH = 1 << (SEC_W + OFF_W);
  localparam int CMAX  = (ERASE_CYC > PROG_CYC ? ERASE_CYC : PROG_CYC) > SLOTS ?
                         (ERASE_CYC > PROG_CYC ? ERASE_CYC : PROG_CYC) : SLOTS;
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [2:0] {IDLE, E_WAIT, E_SWEEP, P_WAIT, P_SWEEP} state_t;

  state_t               state;
  logic [CNT_W-1:0]     cnt, limit;
  logic [SEC_W-1:0]     sec_q;
  logic [SLOTS-1:0]     pval;
  logic                 last7;
  logic [7:0]           pbuf [SLOTS];
  logic [7:0]           mem  [DEPTH];
  logic                 at_end, accept_wr;
  logic [OFF_W-1:0]     idx;

  assign busy      = (state != IDLE);
  assign accept_wr = buf_wr && !busy;
  assign idx       = cnt[OFF_W-1:0];
  assign at_end    = (cnt == limit);

  always_comb begin
    unique case (state)
      E_WAIT:  limit = CNT_W'(ERASE_CYC - 1);
      P_WAIT:  limit = CNT_W'(PROG_CYC - 1);
      default: limit = CNT_W'(SLOTS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      sec_q <= '0;
      pval  <= '0;
      last7 <= 1'b0;
    end else begin
      if (accept_wr) begin
        pval[buf_off] <= 1'b1;
        last7         <= buf_data[7];
      end
      if (state == IDLE) begin
        cnt <= '0;
        if (start) begin
          state <= E_WAIT;
          sec_q <= prog_sec;
        end
      end else if (at_end) begin
        cnt <= '0;
        unique case (state)
          E_WAIT:  state <= E_SWEEP;
          E_SWEEP: state <= P_WAIT;
          P_WAIT:  state <= P_SWEEP;
          default: begin
            state <= IDLE;
            pval  <= '0;
          end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept_wr) pbuf[buf_off] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (state == E_SWEEP)
      mem[{sec_q, idx}] <= 8'hFF;
    else if (state == P_SWEEP)
      mem[{sec_q, idx}] <= pval[idx] ? pbuf[idx] : 8'hFF;
  end

  assign data_oe  = !ce_n && !oe_n && we_n;
  assign data_out = busy ? {~last7, 7'b0} : mem[rd_addr];
endmodule

module sector_prog_seq_chk #(
  parameter int OFF_W     = 8,
  parameter int SEC_W     = 2,
  parameter int ERASE_CYC = 1000,
  parameter int PROG_CYC  = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       buf_wr,
  input logic [7:0] buf_data,
  input logic       start,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       busy,
  input logic [7:0] data_out,
  input logic       data_oe
);
  localparam int TOTAL = ERASE_CYC + PROG_CYC + 2 * (1 << OFF_W);

  logic [31:0] run;
  logic        seen7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      seen7 <= 1'b0;
    end else begin
      run <= busy ? run + 1 : '0;
      if (buf_wr && !busy) seen7 <= buf_data[7];
    end
  end

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_cycle_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == 32'(TOTAL));

  assert_status_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_oe |-> data_out == {~seen7, 7'b0});

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !data_oe);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && run < 32'(TOTAL - 1) |=> busy);
endmodule

bind sector_prog_seq sector_prog_seq_chk #(
  .OFF_W(OFF_W), .SEC_W(SEC_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_data(buf_data),
  .start(start), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sector_prog_seq_test.sv
module sector_prog_seq_test;
  localparam int OFF_W = 8;
  localparam int SEC_W = 2;
  localparam int EC    = 20;
  localparam int PC    = 30;
  localparam int TOTAL = EC + PC + 2 * 256;
  localparam int NLD   = 10;
  localparam logic [15:0] LOADS [NLD] = '{
    16'h10_11, 16'h00_5A, 16'hFE_80, 16'h42_00, 16'h10_99,
    16'h81_7F, 16'h20_FF, 16'h33_C3, 16'h01_01, 16'hC0_A5
  };

  logic clk = 0, rst_n = 0;
  logic buf_wr = 0, start = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [OFF_W-1:0] buf_off = '0;
  logic [7:0] buf_data = '0;
  logic [SEC_W-1:0] prog_sec = '0;
  logic [SEC_W+OFF_W-1:0] rd_addr = '0;
  logic busy, data_oe;
  logic [7:0] data_out;

  int checks = 0, fails = 0;
  logic [7:0] model [1 << (SEC_W + OFF_W)];
  logic [7:0] bufm [256];
  logic [255:0] bval = '0;
  logic last7 = 0;

  always #4 clk = ~clk;

  sector_prog_seq #(.OFF_W(OFF_W), .SEC_W(SEC_W), .ERASE_CYC(EC), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_off(buf_off), .buf_data(buf_data),
    .start(start), .prog_sec(prog_sec), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .busy(busy), .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic load(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    buf_wr = 1; buf_off = off; buf_data = d;
    @(negedge clk);
    buf_wr = 0;
    bufm[off] = d; bval[off] = 1; last7 = d[7];
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [7:0] expv, input string req);
    @(negedge clk);
    ce_n = 0; oe_n = 0; rd_addr = a;
    #1;
    chk(data_oe === 1'b1 && data_out === expv, req, int'(data_out), int'(expv));
    ce_n = 1; oe_n = 1;
  endtask

  task automatic run_cycle(input logic [1:0] sec, input bit poke);
    int n;
    @(negedge clk);
    prog_sec = sec; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy after start", int'(busy), 1);
    n = 1;
    while (busy && n <= TOTAL + 5) begin
      if (n == 100) begin
        ce_n = 0; oe_n = 0; rd_addr = {sec, 8'h10};
        #1;
        chk(data_out === {~last7, 7'b0}, "R5 status poll", int'(data_out), int'({~last7, 7'b0}));
        ce_n = 1; oe_n = 1;
      end
      if (n == 200 && poke) begin
        buf_wr = 1; buf_off = 8'h77; buf_data = 8'h12; start = 1;
      end
      @(negedge clk);
      buf_wr = 0; start = 0;
      if (busy) n++;
    end
    chk(n == TOTAL, "R2/R8 busy length", n, TOTAL);
    for (int i = 0; i < 256; i++) model[{sec, i[7:0]}] = bval[i] ? bufm[i] : 8'hFF;
    bval = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10 busy in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R10 idle after reset", int'(busy), 0);

    // R10: empty buffer after reset, poll bit 7 from reset value 0
    run_cycle(2'd3, 0);
    rd_chk({2'd3, 8'h00}, 8'hFF, "R10 empty buffer gives FF");
    rd_chk({2'd3, 8'hC0}, 8'hFF, "R10 empty buffer gives FF");

    // Table walk: load vectors, program sector 1 with mid-cycle poke
    for (int i = 0; i < NLD; i++) load(LOADS[i][15:8], LOADS[i][7:0]);
    run_cycle(2'd1, 1);
    for (int i = 0; i < NLD; i++)
      rd_chk({2'd1, LOADS[i][15:8]}, model[{2'd1, LOADS[i][15:8]}], "R4 loaded byte");
    rd_chk({2'd1, 8'h10}, 8'h99, "R4 last write to slot wins");
    rd_chk({2'd1, 8'hFF}, 8'hFF, "R3 unloaded location FF");
    rd_chk({2'd1, 8'h77}, 8'hFF, "R8 write during busy ignored");
    rd_chk({2'd1, 8'hC0}, 8'hA5, "R6 true bit 7 after cycle");

    // R7 enable gating
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 1; #1;
    chk(data_oe === 1'b0, "R7 oe_n high", int'(data_oe), 0);
    oe_n = 0; we_n = 0; #1;
    chk(data_oe === 1'b0, "R7 we_n low", int'(data_oe), 0);
    ce_n = 1; we_n = 1; #1;
    chk(data_oe === 1'b0, "R7 ce_n high", int'(data_oe), 0);
    oe_n = 1;

    // Second cycle, sector 2, last bit 7 = 0
    load(8'h05, 8'hE1);
    load(8'h06, 8'h3C);
    run_cycle(2'd2, 0);
    rd_chk({2'd2, 8'h05}, 8'hE1, "R4 second cycle");
    rd_chk({2'd2, 8'h06}, 8'h3C, "R6 second cycle");
    rd_chk({2'd2, 8'h10}, 8'hFF, "R3 buffer cleared between cycles");
    rd_chk({2'd2, 8'h77}, 8'hFF, "R8 poke not carried over");
    rd_chk({2'd1, 8'h42}, 8'h00, "R9 other sector intact");
    rd_chk({2'd3, 8'h05}, 8'hFF, "R9 other sector intact");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule